// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Infrared Pulse Decoding

This block turns an asynchronous serial line into parallel words. It runs on the system clock and treats a one-cycle enable, `tick16`, as its timebase, with sixteen enables to each bit period. In the standard line mode, a falling edge on the line starts a frame. Each bit, start bit included, is then resolved by a three-sample majority vote taken around the middle of its bit period. The block gathers seven or eight data bits, least significant bit first, and an optional ninth bit. It then checks the first stop bit.

In infrared mode, a data 0 arrives as a narrow pulse at the start of its bit period, and a data 1 is the absence of a pulse. The decision is made at mid-pulse. A pulse that lasts only one sample period is treated as noise. Each finished frame is presented on `word_o`, `ninth_o` and `frame_err`, together with a one-cycle `word_valid` strobe. Storage of words, the host interface and rate generation are left to the surrounding logic.

Top module: `oversamp_rx`

## Requirements
- R1: A frame starts only on a high-to-low change: at a `tick16` where the synchronized line reads 0 and the previous sample read 1. This sample is sample 1 of the start bit. A line that stays low starts nothing.
- R2: In standard mode, the value of each bit is the majority of its samples 7, 8 and 9, counting samples 1 to 16 from the detection sample. A single deviating sample in that window does not change the bit. Two deviating samples do.
- R3: If the start bit's vote reads 1, the frame is dropped, no word is emitted, and the receiver waits for a new falling edge.
- R4: With `cfg_short`=0, eight data bits are received. With `cfg_short`=1, seven are received and `word_o[7]` is 0. The first data bit after the start bit lands in `word_o[0]`.
- R5: With `cfg_ninth`=1, one extra bit follows the data and is passed unchecked to `ninth_o`. With `cfg_ninth`=0, no extra bit is received and `ninth_o` is 0.
- R6: A 0 read at the first stop bit emits the word with `frame_err`=1. The receiver then hunts for a start bit again.
- R7: `frame_err` keeps its value between words. It clears with the next word whose stop bit reads 1. One stop bit is enough, so frames may follow each other with no idle time, and a second stop bit is accepted as idle.
- R8: In infrared mode (`cfg_irda`=1), the line is active when it is at level `IRDA_ACT_HIGH` (default 0, active low). A bit is 0 when the line is active at both sample 1 and sample 2 of its period, and 1 otherwise. The decision is made at sample 2.
- R9: In infrared mode, an active level that lasts a single sample period starts no frame and does not turn a 1 bit into a 0.
- R10: `word_valid` is high for exactly one clock, in the cycle after the `tick16` that decides the stop bit. Reset clears `word_valid`, `word_o`, `ninth_o` and `frame_err` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable, sixteen per bit period |
| rx_in | input | 1 | Asynchronous serial line |
| cfg_short | input | 1 | 1 selects seven data bits |
| cfg_ninth | input | 1 | 1 adds a raw ninth bit |
| cfg_irda | input | 1 | 1 selects infrared pulse decoding |
| word_o | output | DATA_W | Received data word |
| ninth_o | output | 1 | Received ninth bit |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| frame_err | output | 1 | Sticky stop-bit error flag |

## Verification
The assertions assume that `tick16` is a single-cycle pulse that recurs at a steady spacing longer than the synchronizer delay. They also assume that the mode inputs are steady at the falling edge that opens a frame, since the block latches them there. The stimulus meets both conditions. It raises `tick16` one clock in four. It changes the line half a clock after an enable, so each change is seen at exactly the next enable, and every driven slot maps to one sample. It sets the mode inputs only while the line is idle and high.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;

  // two-of-three vote
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // bit decision: standard mode votes, infrared mode needs two active samples
  // (s holds data levels, oldest in s[2])
  function automatic logic bit_decide(input logic irda, input logic [2:0] s);
    return irda ? (s[1] | s[0]) : vote3(s);
  endfunction

  // zero-based sample index at which a bit is decided
  function automatic int unsigned decide_slot(input logic irda, input int unsigned osr);
    return irda ? 1 : osr / 2;
  endfunction

endpackage

// File: rtl/osrx_front.sv
module osrx_front #(
  parameter bit IRDA_ACT_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_raw,
  input  logic       mode_irda,
  output logic [2:0] hist_now,
  output logic       fall_seen
);

  logic [1:0] sync_q;
  logic [1:0] hist_q;
  logic       level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rx_raw};
    end
  end

  // data level: 1 = mark; an active-high infrared pulse is inverted
  always_comb begin
    if (mode_irda && IRDA_ACT_HIGH) level = ~sync_q[1];
    else                            level = sync_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
    end else if (tick) begin
      hist_q <= {hist_q[0], level};
    end
  end

  assign hist_now  = {hist_q, level};
  assign fall_seen = tick & hist_q[0] & ~level;

endmodule

// File: rtl/osrx_seq.sv
module osrx_seq
  import osrx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fall_seen,
  input  logic [2:0] hist_now,
  input  logic       cfg_short,
  input  logic       cfg_ninth,
  input  logic       cfg_irda,
  output logic       mode_irda,
  output logic       lat_short,
  output logic       lat_ninth,
  output logic       decide_tick,
  output logic       bit_val,
  output logic       data_take,
  output logic       ninth_take,
  output logic       stop_take,
  output logic       false_start
);

  localparam int CNT_W = $clog2(OSR);
  localparam int BI_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BI_W-1:0]  bidx_q;
  logic             lat_irda_q;
  logic             lat_short_q;
  logic             lat_ninth_q;
  logic             busy;
  logic             bit_end;
  logic [CNT_W-1:0] dec_idx;
  logic [BI_W-1:0]  last_idx;

  assign busy      = (state_q != ST_IDLE);
  assign mode_irda = busy ? lat_irda_q : cfg_irda;
  assign dec_idx   = CNT_W'(decide_slot(lat_irda_q, OSR));
  assign last_idx  = lat_short_q ? BI_W'(DATA_W - 2) : BI_W'(DATA_W - 1);

  assign decide_tick = tick & busy & (cnt_q == dec_idx);
  assign bit_end     = tick & busy & (cnt_q == CNT_LAST);
  assign bit_val     = bit_decide(lat_irda_q, hist_now);

  assign false_start = decide_tick & (state_q == ST_START) & bit_val;
  assign data_take   = decide_tick & (state_q == ST_DATA);
  assign ninth_take  = decide_tick & (state_q == ST_NINTH);
  assign stop_take   = decide_tick & (state_q == ST_STOP);

  assign lat_short = lat_short_q;
  assign lat_ninth = lat_ninth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bidx_q      <= '0;
      lat_irda_q  <= 1'b0;
      lat_short_q <= 1'b0;
      lat_ninth_q <= 1'b0;
    end else if (tick) begin
      if (!busy) begin
        if (fall_seen) begin
          state_q     <= ST_START;
          cnt_q       <= CNT_W'(1);
          lat_irda_q  <= cfg_irda;
          lat_short_q <= cfg_short;
          lat_ninth_q <= cfg_ninth;
        end
      end else begin
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (false_start || stop_take) begin
          state_q <= ST_IDLE;
        end else if (bit_end) begin
          if (state_q == ST_START) begin
            state_q <= ST_DATA;
            bidx_q  <= '0;
          end else if (state_q == ST_DATA) begin
            if (bidx_q == last_idx) state_q <= lat_ninth_q ? ST_NINTH : ST_STOP;
            else                    bidx_q  <= bidx_q + 1'b1;
          end else if (state_q == ST_NINTH) begin
            state_q <= ST_STOP;
          end
        end
      end
    end
  end

endmodule

// File: rtl/osrx_asm.sv
module osrx_asm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_take,
  input  logic              ninth_take,
  input  logic              stop_take,
  input  logic              bit_val,
  input  logic              lat_short,
  input  logic              lat_ninth,
  output logic [DATA_W-1:0] word_o,
  output logic              ninth_o,
  output logic              word_valid,
  output logic              frame_err
);

  logic [DATA_W-1:0] sh_q;
  logic              ninth_q;

  // a short word sits in the upper bits of the shifter
  function automatic logic [DATA_W-1:0] align_word(input logic [DATA_W-1:0] s,
                                                   input logic short7);
    return short7 ? {1'b0, s[DATA_W-1:1]} : s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      ninth_q <= 1'b0;
    end else begin
      if (data_take)  sh_q    <= {bit_val, sh_q[DATA_W-1:1]};
      if (ninth_take) ninth_q <= bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o     <= '0;
      ninth_o    <= 1'b0;
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      word_valid <= stop_take;
      if (stop_take) begin
        word_o    <= align_word(sh_q, lat_short);
        ninth_o   <= lat_ninth & ninth_q;
        frame_err <= ~bit_val;
      end
    end
  end

endmodule

// File: rtl/oversamp_rx.sv
module oversamp_rx #(
  parameter int OSR           = 16,
  parameter int DATA_W        = 8,
  parameter bit IRDA_ACT_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              cfg_short,
  input  logic              cfg_ninth,
  input  logic              cfg_irda,
  output logic [DATA_W-1:0] word_o,
  output logic              ninth_o,
  output logic              word_valid,
  output logic              frame_err
);

  logic [2:0] hist_now;
  logic       fall_seen;
  logic       mode_irda;
  logic       lat_short;
  logic       lat_ninth;
  logic       decide_tick;
  logic       bit_val;
  logic       data_take;
  logic       ninth_take;
  logic       stop_take;
  logic       false_start;

  osrx_front #(
    .IRDA_ACT_HIGH(IRDA_ACT_HIGH)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rx_raw    (rx_in),
    .mode_irda (mode_irda),
    .hist_now  (hist_now),
    .fall_seen (fall_seen)
  );

  osrx_seq #(
    .OSR   (OSR),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick16),
    .fall_seen   (fall_seen),
    .hist_now    (hist_now),
    .cfg_short   (cfg_short),
    .cfg_ninth   (cfg_ninth),
    .cfg_irda    (cfg_irda),
    .mode_irda   (mode_irda),
    .lat_short   (lat_short),
    .lat_ninth   (lat_ninth),
    .decide_tick (decide_tick),
    .bit_val     (bit_val),
    .data_take   (data_take),
    .ninth_take  (ninth_take),
    .stop_take   (stop_take),
    .false_start (false_start)
  );

  osrx_asm #(
    .DATA_W(DATA_W)
  ) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_take  (data_take),
    .ninth_take (ninth_take),
    .stop_take  (stop_take),
    .bit_val    (bit_val),
    .lat_short  (lat_short),
    .lat_ninth  (lat_ninth),
    .word_o     (word_o),
    .ninth_o    (ninth_o),
    .word_valid (word_valid),
    .frame_err  (frame_err)
  );

endmodule

// File: rtl/osrx_chk.sv
module osrx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick16,
  input logic [DATA_W-1:0] word_o,
  input logic              ninth_o,
  input logic              word_valid,
  input logic              frame_err,
  input logic              decide_tick,
  input logic              false_start,
  input logic              bit_val,
  input logic              lat_short,
  input logic              lat_ninth
);

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r10_after_decision: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(decide_tick));

  a_r1_decide_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    decide_tick |-> tick16);

  a_r3_false_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> !word_valid);

  a_r4_short_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && lat_short) |-> !word_o[DATA_W-1]);

  a_r5_ninth_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !lat_ninth) |-> !ninth_o);

  a_r6_err_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (frame_err == !$past(bit_val)));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_err) |-> word_valid);

endmodule

bind oversamp_rx osrx_chk #(
  .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick16      (tick16),
  .word_o      (word_o),
  .ninth_o     (ninth_o),
  .word_valid  (word_valid),
  .frame_err   (frame_err),
  .decide_tick (decide_tick),
  .false_start (false_start),
  .bit_val     (bit_val),
  .lat_short   (lat_short),
  .lat_ninth   (lat_ninth)
);

// File: tb/oversamp_rx_tb_top.sv
module oversamp_rx_tb_top;

  localparam int   DW  = 8;
  localparam logic ACT = 1'b0;  // infrared active level (default polarity)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick16 = 1'b0;
  logic          rx_in = 1'b1;
  logic          cfg_short = 1'b0;
  logic          cfg_ninth = 1'b0;
  logic          cfg_irda = 1'b0;
  logic [DW-1:0] word_o;
  logic          ninth_o;
  logic          word_valid;
  logic          frame_err;
  logic [1:0]    phase = 2'd0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit prev_v = 1'b0;

  typedef struct {
    logic [DW-1:0] w;
    logic          n;
    logic          fe;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  always @(negedge clk) begin
    phase  <= phase + 2'd1;
    tick16 <= (phase == 2'd2);
  end

  oversamp_rx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .rx_in      (rx_in),
    .cfg_short  (cfg_short),
    .cfg_ninth  (cfg_ninth),
    .cfg_irda   (cfg_irda),
    .word_o     (word_o),
    .ninth_o    (ninth_o),
    .word_valid (word_valid),
    .frame_err  (frame_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        check(!prev_v, "R10 strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 R9 word with nothing expected", word_o, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(word_o == e.w, {e.tag, " word"}, word_o, e.w);
          check(ninth_o == e.n, {e.tag, " ninth bit R5"}, ninth_o, e.n);
          check(frame_err == e.fe, {e.tag, " frame error R6"}, frame_err, e.fe);
        end
      end
      prev_v <= word_valid;
    end
  end

  // one slot = one sample: change the line just after an enable
  task automatic slot(input logic v);
    do @(posedge clk); while (!tick16);
    @(negedge clk);
    rx_in = v;
  endtask

  task automatic slots(input logic v, input int n);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  function automatic logic raw_sample(input logic v, input bit irda, input int i,
                                      input logic [15:0] flip);
    logic s;
    if (irda) s = (v == 1'b0 && i < 3) ? ACT : ~ACT;
    else      s = v;
    return s ^ flip[i];
  endfunction

  // value the line carries for one bit, worked out from R2 / R8
  function automatic logic eff_bit(input logic v, input bit irda, input logic [15:0] flip);
    int ones = 0;
    if (irda) begin
      return !((raw_sample(v, 1, 0, flip) == ACT) && (raw_sample(v, 1, 1, flip) == ACT));
    end
    for (int i = 6; i <= 8; i++) if (raw_sample(v, 0, i, flip)) ones++;
    return (ones >= 2);
  endfunction

  task automatic send_bit(input logic v, input bit irda, input logic [15:0] flip);
    for (int i = 0; i < 16; i++) slot(raw_sample(v, irda, i, flip));
  endtask

  task automatic send_frame(input string tag, input logic [7:0] data, input logic nb,
                            input bit short7, input bit par, input bit irda,
                            input int stops, input bit bad, input int fbit,
                            input logic [15:0] flip, input int gap);
    exp_t e;
    int   n;
    cfg_short = short7;
    cfg_ninth = par;
    cfg_irda  = irda;
    n = short7 ? 7 : 8;
    e.w = '0;
    for (int i = 0; i < n; i++) e.w[i] = eff_bit(data[i], irda, (i == fbit) ? flip : 16'h0);
    e.n   = par ? nb : 1'b0;
    e.fe  = bad;
    e.tag = tag;
    exp_q.push_back(e);
    send_bit(1'b0, irda, 16'h0);
    for (int i = 0; i < n; i++) send_bit(data[i], irda, (i == fbit) ? flip : 16'h0);
    if (par) send_bit(nb, irda, 16'h0);
    send_bit(bad ? 1'b0 : 1'b1, irda, 16'h0);
    if (stops == 2 && !bad) send_bit(1'b1, irda, 16'h0);
    slots(irda ? ~ACT : 1'b1, gap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired with %0d words pending", exp_q.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(word_valid == 1'b0, "R10 reset strobe", word_valid, 0);
    check(word_o == '0, "R10 reset word", word_o, 0);
    check(frame_err == 1'b0, "R10 reset error flag", frame_err, 0);
    rst_n = 1'b1;
    slots(1'b1, 20);

    // standard mode, word lengths and the ninth bit
    send_frame("R4 eight bits", 8'hA5, 1'b0, 0, 0, 0, 1, 0, -1, 16'h0, 20);
    send_frame("R4 seven bits", 8'hFF, 1'b0, 1, 0, 0, 1, 0, -1, 16'h0, 20);
    send_frame("R5 ninth one", 8'h3C, 1'b1, 0, 1, 0, 1, 0, -1, 16'h0, 20);
    send_frame("R5 ninth zero", 8'hC3, 1'b0, 0, 1, 0, 1, 0, -1, 16'h0, 20);
    send_frame("R5 ninth off", 8'h81, 1'b1, 0, 0, 0, 1, 0, -1, 16'h0, 20);
    send_frame("R5 seven bits plus ninth", 8'h55, 1'b1, 1, 1, 0, 1, 0, -1, 16'h0, 20);
    send_frame("R7 two stop bits", 8'h5A, 1'b0, 0, 0, 0, 2, 0, -1, 16'h0, 20);

    // majority window: samples 7, 8, 9 are zero-based 6, 7, 8
    send_frame("R2 one sample flipped", 8'hFF, 1'b0, 0, 0, 0, 1, 0, 3, 16'h0040, 20);
    send_frame("R2 two samples flipped", 8'hFF, 1'b0, 0, 0, 0, 1, 0, 3, 16'h0180, 20);
    send_frame("R2 flips outside window", 8'h00, 1'b0, 0, 0, 0, 1, 0, 5, 16'hFE3F, 20);

    // false starts produce no word (monitor flags any)
    slots(1'b0, 3);
    slots(1'b1, 40);
    slots(1'b0, 7);
    slots(1'b1, 40);
    check(exp_q.size() == 0, "R3 false start emitted nothing", exp_q.size(), 0);
    send_frame("R3 recovery after false start", 8'h69, 1'b0, 0, 0, 0, 1, 0, -1, 16'h0, 20);

    // framing error, line held low afterwards
    send_frame("R6 bad stop", 8'h12, 1'b0, 0, 0, 0, 1, 1, -1, 16'h0, 0);
    slots(1'b0, 40);
    slots(1'b1, 30);
    check(exp_q.size() == 0, "R1 held-low line started no frame", exp_q.size(), 0);
    check(frame_err == 1'b1, "R7 error flag held between words", frame_err, 1);
    send_frame("R7 error cleared by good frame", 8'h34, 1'b0, 0, 0, 0, 1, 0, -1, 16'h0, 20);

    // back-to-back frames with a single stop bit
    send_frame("R7 back to back first", 8'hE1, 1'b0, 0, 0, 0, 1, 0, -1, 16'h0, 0);
    send_frame("R7 back to back second", 8'h1E, 1'b0, 0, 0, 0, 1, 0, -1, 16'h0, 20);

    // infrared mode
    slots(~ACT, 20);
    send_frame("R8 infrared eight bits", 8'h96, 1'b0, 0, 0, 1, 1, 0, -1, 16'h0, 20);
    send_frame("R8 infrared ninth bit", 8'h0F, 1'b1, 0, 1, 1, 1, 0, -1, 16'h0, 20);
    send_frame("R8 infrared seven bits", 8'hAA, 1'b0, 1, 0, 1, 1, 0, -1, 16'h0, 20);
    send_frame("R8 infrared bad stop", 8'h77, 1'b0, 0, 0, 1, 1, 1, -1, 16'h0, 20);
    send_frame("R8 infrared error cleared", 8'h44, 1'b0, 0, 0, 1, 1, 0, -1, 16'h0, 20);

    // one-sample glitches
    slot(ACT);
    slots(~ACT, 40);
    check(exp_q.size() == 0, "R9 idle glitch started no frame", exp_q.size(), 0);
    send_frame("R9 glitch at sample 2", 8'hFF, 1'b0, 0, 0, 1, 1, 0, 2, 16'h0002, 20);
    send_frame("R9 glitch at sample 1", 8'hFF, 1'b0, 0, 0, 1, 1, 0, 6, 16'h0001, 20);

    slots(~ACT, 40);
    check(exp_q.size() == 0, "R10 every expected word arrived", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule